// File: doc/BRIEF.md
# Four-Channel Staged-Reload PWM Generator

This block produces four independent pulse-width modulated outputs. Each channel is set up through two 32-bit registers. One holds the length of a full cycle and the other holds how long the output stays high in that cycle. Both count cycles of the input clock. Software reaches the registers through a plain word-addressed port. A write is captured on the clock edge that samples `we_i`. A read returns the addressed register in the same cycle.

The registers are shadows. Each channel runs from private active copies. These copies reload only when the running cycle ends, or at once while the channel is idle. A rewrite therefore never cuts a cycle short or stretches it. A period of zero is the idle state. In that state the output rests high, which is also its state after reset. Clearing both registers stops a channel cleanly at the end of its current cycle.

Top module: `pwm_quad_shadow`

## Requirements
- R1: There are four channels, numbered 0 to 3. Channel n's high-time register sits at word address 2n (byte offset n*8). Its period register sits at word address 2n+1 (byte offset n*8+4).
- R2: While reset is asserted and after it is released, all registers read zero and every output is high.
- R3: A read of a mapped word address returns, in the same cycle, the last value written there. It never returns the active copy.
- R4: Word addresses 8 to 15 read as zero, and writes to them change no register and no output.
- R5: With an active period P>0 and high time H<P, the output is high for the first H clock cycles of each P-cycle period and low for the rest.
- R6: A write to a running channel leaves the current period unchanged. The new values apply from the first cycle of the next period. A write captured on the edge that ends a period applies to the period that begins at that edge.
- R7: A channel whose active period is zero is idle with its output high, whatever its high-time holds. Writing period 0 stops the channel at the end of its current period.
- R8: An idle channel loads new values on the edge that captures a write to it. Its first period begins in the cycle that follows that edge.
- R9: If H>=P, the output stays high for the whole period. If H=0 and P>0, it stays low for the whole period.
- R10: Activity on one channel has no effect on the timing or output of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all counting is in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address of the register access |
| we_i | input | 1 | Write strobe, captured on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 4 | One PWM output per channel, bit n for channel n |

## Verification
The critical collision is a register write captured on the same edge at which a channel finishes its period. The write and the reload of the active copy then fall in one cycle, and the reload must take the freshly written value. The bench provokes this by watching its own model's cycle position and placing a write on the final cycle of a period. It also places writes mid-period and on idle channels. A behavioural per-channel model stages the values in the same way, and every output and read value is compared against it on every clock. A directed sequence also confirms that a mid-period rewrite leaves the rest of the current period intact and that the new high time shows from the first cycle of the next period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned NUM_CH = 4;
  parameter int unsigned ADDR_W = 4;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    word_t hi;
    word_t per;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = pwm_pkg::NUM_CH,
  parameter int unsigned ADDR_W = pwm_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output chan_cfg_t         cfg_d_o [NUM_CH]
);
  chan_cfg_t cfg_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] HiAddr  = ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] PerAddr = ADDR_W'(2 * c + 1);
    logic wr_hi, wr_per;

    assign wr_hi  = we_i && (addr_i == HiAddr);
    assign wr_per = we_i && (addr_i == PerAddr);

    // next-state value, forwarded so a reload on the write edge sees it
    always_comb begin
      cfg_d_o[c] = cfg_q[c];
      if (wr_hi)  cfg_d_o[c].hi  = wdata_i;
      if (wr_per) cfg_d_o[c].per = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[c] <= '0;
      else         cfg_q[c] <= cfg_d_o[c];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(2 * c))     rdata_o = cfg_q[c].hi;
      if (addr_i == ADDR_W'(2 * c + 1)) rdata_o = cfg_q[c].per;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cfg_t cfg_d_i,
  output logic      pwm_o,
  output word_t     act_per_o,
  output word_t     act_hi_o,
  output word_t     cnt_o
);
  word_t act_per, act_hi, cnt;
  logic  idle, wrap, load;

  assign idle = (act_per == '0);
  assign wrap = (cnt == act_per - word_t'(1));
  assign load = idle || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per <= '0;
      act_hi  <= '0;
      cnt     <= '0;
    end else if (load) begin
      act_per <= cfg_d_i.per;
      act_hi  <= cfg_d_i.hi;
      cnt     <= '0;
    end else begin
      cnt     <= cnt + word_t'(1);
    end
  end

  // high while idle, else high for the first act_hi cycles
  assign pwm_o     = idle || (cnt < act_hi);
  assign act_per_o = act_per;
  assign act_hi_o  = act_hi;
  assign cnt_o     = cnt;
endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = pwm_pkg::NUM_CH,
  parameter int unsigned ADDR_W = pwm_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  chan_cfg_t cfg_d [NUM_CH];
  word_t     act_per [NUM_CH];
  word_t     act_hi  [NUM_CH];
  word_t     cnt     [NUM_CH];

  pwm_regfile #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .cfg_d_o(cfg_d)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_d_i  (cfg_d[c]),
      .pwm_o    (pwm_o[c]),
      .act_per_o(act_per[c]),
      .act_hi_o (act_hi[c]),
      .cnt_o    (cnt[c])
    );
  end
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = pwm_pkg::NUM_CH,
  parameter int unsigned ADDR_W = pwm_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] pwm_o,
  input word_t             act_per [NUM_CH],
  input word_t             act_hi  [NUM_CH],
  input word_t             cnt     [NUM_CH]
);
  localparam logic [ADDR_W-1:0] NumWords = ADDR_W'(2 * NUM_CH);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_high_R2: assert (&pwm_o);
    end
  end

  assert_readback_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && ($past(addr_i) == addr_i) && (addr_i < NumWords))
      |-> (rdata_o == $past(wdata_i)));

  assert_unmapped_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= NumWords) |-> (rdata_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per[c] != '0) |-> (cnt[c] < act_per[c]));

    assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt[c] != '0) |-> (cnt[c] == $past(cnt[c]) + 32'd1));

    assert_hold_mid_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt[c] != '0) |-> ($stable(act_per[c]) && $stable(act_hi[c])));

    assert_idle_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_per[c] == '0) |-> pwm_o[c]);

    assert_full_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_per[c] != '0) && (act_hi[c] >= act_per[c])) |-> pwm_o[c]);

    assert_zero_high_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_per[c] != '0) && (act_hi[c] == '0)) |-> !pwm_o[c]);
  end
endmodule

bind pwm_quad_shadow pwm_checker #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pwm_o  (pwm_o),
  .act_per(act_per),
  .act_hi (act_hi),
  .cnt    (cnt)
);

// File: tb/sim_pwm_quad_shadow.sv
`timescale 1ns/1ps
module sim_pwm_quad_shadow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit run_cmp = 0;
  string cur_req = "R5";

  longint m_hi [4], m_per [4], a_hi [4], a_per [4], m_cnt [4];

  always #5 clk = ~clk;

  pwm_quad_shadow u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .pwm_o  (pwm)
  );

  // behavioural reference: staged registers and per-channel cycle position
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_hi[c] = 0; m_per[c] = 0; a_hi[c] = 0; a_per[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      longint n_hi [4], n_per [4];
      for (int c = 0; c < 4; c++) begin
        n_hi[c] = m_hi[c];
        n_per[c] = m_per[c];
        if (we && addr == 4'(2*c))   n_hi[c]  = wdata;
        if (we && addr == 4'(2*c+1)) n_per[c] = wdata;
      end
      for (int c = 0; c < 4; c++) begin
        if (a_per[c] == 0 || m_cnt[c] == a_per[c] - 1) begin
          a_per[c] = n_per[c]; a_hi[c] = n_hi[c]; m_cnt[c] = 0;
        end else begin
          m_cnt[c] = m_cnt[c] + 1;
        end
        m_hi[c] = n_hi[c];
        m_per[c] = n_per[c];
      end
    end
  end

  function automatic logic exp_pwm(int c);
    if (a_per[c] == 0) return 1'b1;
    return (m_cnt[c] < a_hi[c]);
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    if (a >= 4'd8) return '0;
    if (a[0]) return m_per[a >> 1][31:0];
    return m_hi[a >> 1][31:0];
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      for (int c = 0; c < 4; c++)
        check(cur_req, $sformatf("pwm ch%0d", c), longint'(pwm[c]), longint'(exp_pwm(c)));
      check(addr >= 4'd8 ? "R4" : "R3", $sformatf("rdata addr=%0d", addr),
            longint'(rdata), longint'(exp_rd(addr)));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      addr = 4'(a);
    end
    @(negedge clk);
  endtask

  task automatic wait_cnt(int c, longint v);
    do begin
      @(posedge clk); #2;
    end while (m_cnt[c] != v || a_per[c] == 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R2: reset state
    #12;
    check("R2", "pwm in reset", longint'(pwm), 64'hF);
    check("R2", "rdata in reset", longint'(rdata), 0);
    @(negedge clk); rst_n = 1'b1;
    run_cmp = 1;
    idle(3);
    check("R2", "pwm after reset", longint'(pwm), 64'hF);
    cur_req = "R1";
    sweep_reads();

    // R1 / R3: map each register with a distinct value, read back
    for (int c = 0; c < 4; c++) begin
      wr(4'(2*c), 32'hA0 + 32'(c));
      wr(4'(2*c+1), 32'h0);
    end
    sweep_reads();
    @(negedge clk); addr = 4'd6;
    #1 check("R1", "ch3 high-time word 6", longint'(rdata), 64'hA3);

    // R8: idle channel starts on write edge; R5 basic waveform
    cur_req = "R8";
    for (int c = 0; c < 4; c++) wr(4'(2*c), 32'h0);
    wr(4'd0, 32'd3);
    wr(4'd1, 32'd8);
    #1 check("R8", "ch0 first cycle high", longint'(pwm[0]), 1);
    cur_req = "R5";
    idle(30);

    // R9: H>=P and H=0 on other channels; R10 independence
    cur_req = "R9";
    wr(4'd2, 32'd10); wr(4'd3, 32'd5);
    wr(4'd4, 32'd0);  wr(4'd5, 32'd4);
    wr(4'd6, 32'd1);  wr(4'd7, 32'd1);
    idle(25);
    cur_req = "R10";
    wr(4'd6, 32'd0);
    idle(12);
    wr(4'd6, 32'd2); wr(4'd7, 32'd3);
    idle(15);

    // R6: mid-period rewrite, directed
    cur_req = "R6";
    wr(4'd0, 32'd2); wr(4'd1, 32'd6);
    wait_cnt(0, 0); wait_cnt(0, 1);
    wr(4'd0, 32'd5);
    #1 check("R6", "ch0 rest of period low cnt2", longint'(pwm[0]), 0);
    repeat (3) begin
      @(posedge clk); #2;
      check("R6", "ch0 old period tail low", longint'(pwm[0]), 0);
    end
    begin
      int highs = 0;
      @(posedge clk); #2;
      check("R6", "ch0 new high at period start", longint'(pwm[0]), 1);
      if (pwm[0]) highs++;
      repeat (5) begin
        @(posedge clk); #2;
        if (pwm[0]) highs++;
      end
      check("R6", "ch0 highs in new period", highs, 5);
    end

    // R6: write landing on the boundary edge
    wait_cnt(0, 5);
    wr(4'd0, 32'd1);
    wait_cnt(1, 2);
    wr(4'd2, 32'd3);
    idle(20);

    // R4: unmapped writes ignored
    cur_req = "R4";
    for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    sweep_reads();
    idle(10);

    // R7: stop channels
    cur_req = "R7";
    wr(4'd1, 32'd0);
    wr(4'd0, 32'd0);
    wr(4'd5, 32'd0);
    idle(15);
    check("R7", "ch0 parked high", longint'(pwm[0]), 1);
    check("R7", "ch2 parked high", longint'(pwm[2]), 1);
    wr(4'd3, 32'd0);
    idle(15);
    check("R7", "ch1 parked with nonzero high-time", longint'(pwm[1]), 1);

    run_cmp = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule